// File: doc/BRIEF.md
# SD host event status and interrupt enable unit

This unit gathers the event and error indications of an SD host controller into one 32-bit status word and drives a single interrupt line and a wake-up line. Command, data and card-detect logic feed it single-cycle event pulses, which set sticky flags. Software clears a flag by writing a 1 to it. Buffer fill state, buffer readiness and the bus clock state are level conditions. The word shows a registered copy of them, and writes do not affect them.

A second word holds the interrupt and wake-up enables. The interrupt line is the OR of each enabled source. Most sources are sticky flags. Buffer readiness is a level, and the DAT0 line state comes in directly. The unit also reports a summary of the error flags. The write-CRC outcome is kept as a 2-bit code inside the status word, and a separate output marks the case where the card sent back no CRC status.

Top module: `sdh_irq_unit`

## Requirements
- R1: After reset every status bit, every enable bit, `irq_o`, `wake_o`, `err_o` and `no_crc_o` is 0.
- R2: An `ev_i` pulse on a sticky bit (31, 30, 25, 24, 14, 13, 12, 11, 5, 3, 2, 1, 0) sets that status bit on the next clock edge, and the bit stays set after the pulse ends.
- R3: A write with `wr_sel_i`=0 clears every sticky status bit whose data bit is 1. Bits written with 0 keep their value.
- R4: When an event and a write-one-to-clear reach the same sticky bit in the same cycle, the bit ends up set.
- R5: Level bits 29..26 and 8..6 show `lvl_i` one clock later. Status writes do not change them.
- R6: A `crc_vld_i` pulse loads `crc_code_i` into status bits [10:9]. A nonzero code also sets the write-CRC error flag (bit 2). Clearing bit 2 sets the code to 0. Writes to bits [10:9] are ignored. `no_crc_o` is 1 exactly when bit 2 is set and the code is 2.
- R7: `err_o` is 1 while any of status bits 0, 1, 2, 3 or 5 is set.
- R8: `irq_o` is the OR of these terms, written as enable bit paired with its source: 0 with status 11, 1 with status 12, 2 with status 13, 3 with status 6, 4 with status 7, 12 with `dat0_i`, 13 with status 14, 14 with status 30, 15 with status 31.
- R9: `wake_o` is the OR of these terms, written as enable bit paired with its source: 16 with status 30, 17 with status 31, 18 with status 14.
- R10: A write with `wr_sel_i`=1 loads enable bits 0..4 and 12..18. All other enable bits read 0.
- R11: Status bits 4 and 23..15 always read 0, whatever the events and writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_i | input | 1 | Register write strobe |
| wr_sel_i | input | 1 | Write target: 0 status (write one to clear), 1 enables |
| wr_data_i | input | 32 | Write data |
| ev_i | input | 32 | Event pulses, one per status bit position |
| lvl_i | input | 32 | Level conditions, one per status bit position |
| crc_vld_i | input | 1 | Write-CRC outcome valid pulse |
| crc_code_i | input | 2 | Write-CRC outcome code |
| dat0_i | input | 1 | DAT0 line level |
| status_o | output | 32 | Status word |
| int_en_o | output | 32 | Enable word |
| irq_o | output | 1 | Interrupt request |
| wake_o | output | 1 | Wake-up request |
| err_o | output | 1 | Error summary |
| no_crc_o | output | 1 | Card returned no CRC status |

## Verification
The assertions assume that `lvl_i` is stable across reset release. They also assume that `ev_i` and `crc_vld_i` are single-cycle pulses from a synchronous source. Because of this, a flag that is seen set one cycle after its event can be tied to that event. The stimulus drives every input on the falling edge and returns pulses to 0 after a single rising edge. It holds `lvl_i` at 0 during reset. Clear and event are made to collide only in the scenario written for that case.

// File: rtl/sdh_irq_pkg.sv
package sdh_irq_pkg;
  localparam int W = 32;
  localparam logic [W-1:0] STICKY_M = 32'hC300_782F;
  localparam logic [W-1:0] LEVEL_M  = 32'h3C00_01C0;
  localparam logic [W-1:0] ERR_M    = 32'h0000_002F;
  localparam logic [W-1:0] EN_M     = 32'h0007_F01F;
  localparam int CODE_LO = 9;
  localparam int CODE_W  = 2;
  localparam logic [CODE_W-1:0] CODE_NO_CRC = 2'd2;

  // status bit positions used by the interrupt logic
  localparam int S_INS = 31, S_REM = 30, S_SDIO = 14, S_CMD = 13;
  localparam int S_WDONE = 12, S_RDONE = 11, S_BRD = 7, S_BWR = 6, S_WCRC = 2;

  // enable bit positions
  localparam int E_RD = 0, E_WR = 1, E_CMD = 2, E_BWR = 3, E_BRD = 4;
  localparam int E_DAT0 = 12, E_SDIO = 13, E_REM = 14, E_INS = 15;
  localparam int E_WREM = 16, E_WINS = 17, E_WSDIO = 18;
endpackage

// File: rtl/sdh_status_reg.sv
module sdh_status_reg
  import sdh_irq_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic [W-1:0]      clr_mask_i,
  input  logic [W-1:0]      ev_i,
  input  logic [W-1:0]      lvl_i,
  input  logic              crc_vld_i,
  input  logic [CODE_W-1:0] crc_code_i,
  output logic [W-1:0]      status_o
);
  logic [W-1:0]      set_v, clr_v, bit_q;
  logic [CODE_W-1:0] code_q;
  logic              crc_err;

  assign crc_err = crc_vld_i && (crc_code_i != '0);
  assign set_v   = (ev_i & STICKY_M) | (W'(crc_err) << S_WCRC);
  assign clr_v   = clr_i ? clr_mask_i : '0;

  for (genvar i = 0; i < W; i++) begin : g_bit
    if (STICKY_M[i]) begin : g_sticky
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni)        bit_q[i] <= 1'b0;
        else if (set_v[i])  bit_q[i] <= 1'b1;  // event beats clear
        else if (clr_v[i])  bit_q[i] <= 1'b0;
    end else if (LEVEL_M[i]) begin : g_level
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) bit_q[i] <= 1'b0;
        else         bit_q[i] <= lvl_i[i];
    end else begin : g_zero
      assign bit_q[i] = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)              code_q <= '0;
    else if (crc_vld_i)       code_q <= crc_code_i;
    else if (clr_v[S_WCRC])   code_q <= '0;

  assign status_o = bit_q | (W'(code_q) << CODE_LO);
endmodule

// File: rtl/sdh_int_en_reg.sv
module sdh_int_en_reg
  import sdh_irq_pkg::*;
(
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         ld_i,
  input  logic [W-1:0] data_i,
  output logic [W-1:0] en_o
);
  logic [W-1:0] en_q;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)   en_q <= '0;
    else if (ld_i) en_q <= data_i & EN_M;

  assign en_o = en_q;
endmodule

// File: rtl/sdh_irq_comb.sv
module sdh_irq_comb
  import sdh_irq_pkg::*;
(
  input  logic [W-1:0] status_i,
  input  logic [W-1:0] en_i,
  input  logic         dat0_i,
  output logic         irq_o,
  output logic         wake_o,
  output logic         err_o,
  output logic         no_crc_o
);
  logic [8:0] src;

  always_comb begin
    src[0] = en_i[E_RD]   & status_i[S_RDONE];
    src[1] = en_i[E_WR]   & status_i[S_WDONE];
    src[2] = en_i[E_CMD]  & status_i[S_CMD];
    src[3] = en_i[E_BWR]  & status_i[S_BWR];
    src[4] = en_i[E_BRD]  & status_i[S_BRD];
    src[5] = en_i[E_DAT0] & dat0_i;
    src[6] = en_i[E_SDIO] & status_i[S_SDIO];
    src[7] = en_i[E_REM]  & status_i[S_REM];
    src[8] = en_i[E_INS]  & status_i[S_INS];
  end

  assign irq_o    = |src;
  assign wake_o   = (en_i[E_WREM] & status_i[S_REM]) |
                    (en_i[E_WINS] & status_i[S_INS]) |
                    (en_i[E_WSDIO] & status_i[S_SDIO]);
  assign err_o    = |(status_i & ERR_M);
  assign no_crc_o = status_i[S_WCRC] &&
                    (status_i[CODE_LO +: CODE_W] == CODE_NO_CRC);
endmodule

// File: rtl/sdh_irq_unit.sv
module sdh_irq_unit
  import sdh_irq_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        wr_i,
  input  logic        wr_sel_i,
  input  logic [31:0] wr_data_i,
  input  logic [31:0] ev_i,
  input  logic [31:0] lvl_i,
  input  logic        crc_vld_i,
  input  logic [1:0]  crc_code_i,
  input  logic        dat0_i,
  output logic [31:0] status_o,
  output logic [31:0] int_en_o,
  output logic        irq_o,
  output logic        wake_o,
  output logic        err_o,
  output logic        no_crc_o
);
  logic [W-1:0] status, int_en;

  sdh_status_reg i_status (
    .clk_i, .rst_ni,
    .clr_i      (wr_i && !wr_sel_i),
    .clr_mask_i (wr_data_i),
    .ev_i, .lvl_i, .crc_vld_i, .crc_code_i,
    .status_o   (status)
  );

  sdh_int_en_reg i_en (
    .clk_i, .rst_ni,
    .ld_i   (wr_i && wr_sel_i),
    .data_i (wr_data_i),
    .en_o   (int_en)
  );

  sdh_irq_comb i_comb (
    .status_i (status),
    .en_i     (int_en),
    .dat0_i,
    .irq_o, .wake_o, .err_o, .no_crc_o
  );

  assign status_o = status;
  assign int_en_o = int_en;
endmodule

// File: rtl/sdh_irq_chk.sv
module sdh_irq_chk
  import sdh_irq_pkg::*;
(
  input logic        clk_i,
  input logic        rst_ni,
  input logic        wr_i,
  input logic        wr_sel_i,
  input logic [31:0] wr_data_i,
  input logic [31:0] ev_i,
  input logic [31:0] lvl_i,
  input logic        crc_vld_i,
  input logic [31:0] status_o,
  input logic [31:0] int_en_o,
  input logic        irq_o,
  input logic        wake_o,
  input logic        no_crc_o
);
  localparam logic [31:0] CLR_CHK_M = STICKY_M & ~(32'h1 << S_WCRC);

  AST_EVENT_STICKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((ev_i & STICKY_M) != '0) |=>
      ((status_o & $past(ev_i & STICKY_M)) == $past(ev_i & STICKY_M))); // R2

  AST_W1C_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !wr_sel_i) |=>
      ((status_o & CLR_CHK_M & $past(wr_data_i) & ~$past(ev_i)) == '0)); // R3

  AST_LEVEL_FOLLOWS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rst_ni) |-> ((status_o & LEVEL_M) == ($past(lvl_i) & LEVEL_M))); // R5

  AST_NO_CRC_NEEDS_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    no_crc_o |-> status_o[S_WCRC]); // R6

  AST_IRQ_NEEDS_EN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> ((int_en_o & 32'h0000_F01F) != '0)); // R8

  AST_WAKE_NEEDS_EN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_o |-> (int_en_o[18:16] != 3'b000)); // R9

  AST_ENABLE_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_i && wr_sel_i) |=> $stable(int_en_o)); // R10
endmodule

bind sdh_irq_unit sdh_irq_chk i_chk (
  .clk_i, .rst_ni, .wr_i, .wr_sel_i, .wr_data_i, .ev_i, .lvl_i,
  .crc_vld_i, .status_o, .int_en_o, .irq_o, .wake_o, .no_crc_o
);

// File: tb/test_sdh_irq_unit.sv
module test_sdh_irq_unit;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        wr = 1'b0, wr_sel = 1'b0, crc_vld = 1'b0, dat0 = 1'b0;
  logic [31:0] wr_data = '0, ev = '0, lvl = '0;
  logic [1:0]  crc_code = '0;
  logic [31:0] status, int_en;
  logic        irq, wake, err, no_crc;
  int n_chk = 0, n_fail = 0;
  bit  done = 1'b0;

  always #4 clk = ~clk;

  sdh_irq_unit i_sdh_irq_unit (
    .clk_i(clk), .rst_ni(rst_n), .wr_i(wr), .wr_sel_i(wr_sel), .wr_data_i(wr_data),
    .ev_i(ev), .lvl_i(lvl), .crc_vld_i(crc_vld), .crc_code_i(crc_code), .dat0_i(dat0),
    .status_o(status), .int_en_o(int_en), .irq_o(irq), .wake_o(wake),
    .err_o(err), .no_crc_o(no_crc)
  );

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic pulse(input logic [31:0] e);
    @(negedge clk); ev = e; step(); ev = '0;
  endtask

  task automatic wr_reg(input logic sel, input logic [31:0] d);
    @(negedge clk); wr = 1'b1; wr_sel = sel; wr_data = d; step(); wr = 1'b0; wr_data = '0;
  endtask

  task automatic crc_evt(input logic [1:0] c);
    @(negedge clk); crc_vld = 1'b1; crc_code = c; step(); crc_vld = 1'b0; crc_code = '0;
  endtask

  task automatic t_reset();
    chk(status, 32'h0, "R1 status");
    chk(int_en, 32'h0, "R1 enable");
    chk({28'h0, irq, wake, err, no_crc}, 32'h0, "R1 outputs");
  endtask

  task automatic t_sticky();
    pulse(32'hC000_2001);
    step();
    chk(status, 32'hC000_2001, "R2 bits held after pulse");
    pulse(32'h0300_1800);
    chk(status, 32'hC300_3801, "R2 second group accumulates");
    wr_reg(1'b0, 32'hFFFF_FFFF);
    chk(status, 32'h0, "R3 clear all");
  endtask

  task automatic t_w1c();
    pulse(32'h0000_6022);
    wr_reg(1'b0, 32'h0000_2002);
    chk(status, 32'h0000_4020, "R3 selective clear");
    wr_reg(1'b0, 32'h0);
    chk(status, 32'h0000_4020, "R3 zero write keeps");
    wr_reg(1'b0, 32'h0000_4020);
    chk(status, 32'h0, "R3 remainder cleared");
  endtask

  task automatic t_collide();
    pulse(32'h0000_1000);
    @(negedge clk); ev = 32'h0000_1000; wr = 1'b1; wr_sel = 1'b0; wr_data = 32'h0000_1001;
    step(); ev = '0; wr = 1'b0; wr_data = '0;
    chk(status, 32'h0000_1000, "R4 event wins over clear");
    wr_reg(1'b0, 32'h0000_1000);
    chk(status, 32'h0, "R4 later clear works");
  endtask

  task automatic t_level();
    @(negedge clk); lvl = 32'hFFFF_FFFF; step();
    chk(status, 32'h3C00_01C0, "R5 level bits follow");
    wr_reg(1'b0, 32'hFFFF_FFFF);
    chk(status, 32'h3C00_01C0, "R5 writes ignored");
    @(negedge clk); lvl = 32'h0800_0040; step();
    chk(status, 32'h0800_0040, "R5 level partial");
    @(negedge clk); lvl = '0; step();
    chk(status, 32'h0, "R5 level drops");
  endtask

  task automatic t_crc();
    crc_evt(2'd2);
    chk(status, 32'h0000_0404, "R6 code 2 sets flag");
    chk({31'h0, no_crc}, 32'h1, "R6 no crc flagged");
    chk({31'h0, err}, 32'h1, "R7 crc error summary");
    wr_reg(1'b0, 32'h0000_0600);
    chk(status, 32'h0000_0404, "R6 code write ignored");
    crc_evt(2'd1);
    chk(status, 32'h0000_0204, "R6 code 1 loaded");
    chk({31'h0, no_crc}, 32'h0, "R6 code 1 not no-crc");
    wr_reg(1'b0, 32'h0000_0004);
    chk(status, 32'h0, "R6 clear flag zeroes code");
    crc_evt(2'd0);
    chk(status, 32'h0, "R6 code 0 no error");
  endtask

  task automatic t_err();
    pulse(32'h0000_0020);
    chk({31'h0, err}, 32'h1, "R7 resp crc err");
    wr_reg(1'b0, 32'h0000_0020);
    chk({31'h0, err}, 32'h0, "R7 summary clears");
    pulse(32'h0000_0008);
    chk({31'h0, err}, 32'h1, "R7 read crc err");
    wr_reg(1'b0, 32'hFFFF_FFFF);
  endtask

  task automatic t_unused();
    pulse(32'h00FF_8010);
    chk(status, 32'h0, "R11 unused bits stay 0 on events");
    @(negedge clk); lvl = 32'h00FF_8010; step(); @(negedge clk); lvl = '0; step();
    chk(status, 32'h0, "R11 unused bits stay 0 on levels");
  endtask

  task automatic t_enable();
    wr_reg(1'b1, 32'hFFFF_FFFF);
    chk(int_en, 32'h0007_F01F, "R10 writable enable bits");
    wr_reg(1'b1, 32'h0000_0000);
    chk(int_en, 32'h0, "R10 enables cleared");
  endtask

  task automatic t_irq();
    wr_reg(1'b1, 32'h0000_0004);
    pulse(32'h0000_2000);
    chk({31'h0, irq}, 32'h1, "R8 end cmd enabled");
    wr_reg(1'b1, 32'h0000_0001);
    chk({31'h0, irq}, 32'h0, "R8 masked source silent");
    wr_reg(1'b0, 32'h0000_2000);
    @(negedge clk); lvl = 32'h0000_0040; step();
    wr_reg(1'b1, 32'h0000_0008);
    chk({31'h0, irq}, 32'h1, "R8 buffer write ready level");
    @(negedge clk); lvl = '0; step();
    chk({31'h0, irq}, 32'h0, "R8 level released");
    wr_reg(1'b1, 32'h0000_1000);
    @(negedge clk); dat0 = 1'b1; #1;
    chk({31'h0, irq}, 32'h1, "R8 dat0 source");
    dat0 = 1'b0; #1;
    chk({31'h0, irq}, 32'h0, "R8 dat0 low");
    wr_reg(1'b1, 32'h0000_8000);
    pulse(32'h8000_0000);
    chk({31'h0, irq}, 32'h1, "R8 insertion");
    chk({31'h0, wake}, 32'h0, "R9 wake off without enable");
    wr_reg(1'b1, 32'h0002_0000);
    chk({30'h0, irq, wake}, 32'h1, "R9 wake insertion, irq off");
    wr_reg(1'b1, 32'h0001_0000);
    chk({31'h0, wake}, 32'h0, "R9 removal wake no event");
    pulse(32'h4000_0000);
    chk({31'h0, wake}, 32'h1, "R9 removal wake");
    wr_reg(1'b0, 32'hFFFF_FFFF);
    chk({30'h0, irq, wake}, 32'h0, "R9 cleared");
  endtask

  initial begin
    #2000000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #3; t_reset();
    #20; @(negedge clk); rst_n = 1'b1; step();
    t_reset();
    t_sticky();
    t_w1c();
    t_collide();
    t_level();
    t_crc();
    t_err();
    t_unused();
    t_enable();
    t_irq();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule